// File: doc/BRIEF.md
# Static-Seeded One-Bit Branch Direction Predictor

This block holds one direction bit for every instruction slot of a direct-mapped instruction cache. When the cache refills a line, the block loads every slot's bit from the sign of that instruction's PC-relative branch displacement. A negative displacement points backward and loads a 1, which means taken. A positive displacement points forward and loads a 0, which means not taken. The first prediction for a freshly cached branch therefore follows the backward-taken, forward-not-taken rule. After the branch resolves, its bit is overwritten with the real outcome, so from then on the block behaves as a one-bit last-outcome predictor.

The fetch stage drives a slot index and reads the prediction combinationally in the same cycle. The refill logic presents a line number together with the eight displacement sign bits. The execute stage reports a resolved branch as a slot index plus its outcome. The cache data array, tag comparison and instruction decode sit outside this block. The default geometry is 1024 lines of 8 slots, which gives 8192 bits in total. The slot index is `{line, slot}`, with the slot in the low 3 bits.

Top module: `bp_dir_predictor`

## Requirements
- R1: While `rst_n` is low, every bit clears to 0 (not taken), fills and updates are ignored, and `pred_taken` reads 0.
- R2: A fill with `fill_en`=1 makes slot s of `fill_line` predict `fill_signs[s]` from the next clock edge. A sign bit of 1 (backward) means taken, and 0 (forward) means not taken.
- R3: A fill writes all 8 slots of its line in a single cycle and leaves every other line unchanged.
- R4: A resolve with `upd_en`=1 writes `upd_taken` into the bit at `upd_idx` on the next edge and leaves the other slots of that line unchanged.
- R5: When a fill and a resolve target the same line in the same cycle, the fill wins: the whole line takes the fill signs and the resolve is dropped.
- R6: When a fill and a resolve target different lines in the same cycle, both take effect on the same edge.
- R7: `pred_taken` follows `pred_idx` combinationally. A write becomes visible only after the edge that performs it, never in its own cycle.
- R8: In a cycle with `fill_en`=0 and `upd_en`=0, no stored bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all bits |
| fill_en | input | 1 | Line refill strobe |
| fill_line | input | 10 | Line being refilled |
| fill_signs | input | 8 | Displacement sign per slot, bit s for slot s (1 = backward) |
| upd_en | input | 1 | Branch resolution strobe |
| upd_idx | input | 13 | Resolved slot index `{line, slot}` |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |
| pred_idx | input | 13 | Slot index to predict `{line, slot}` |
| pred_taken | output | 1 | Predicted direction (1 = taken) |

## Verification
The prediction read has zero latency: for a given `pred_idx`, `pred_taken` is valid in the same cycle. Fills and resolves land exactly one edge after the cycle that presents them. The bench drives every input just after a falling edge and compares `pred_taken` one nanosecond later, against a model that still holds the state from before the coming rising edge. It applies the model's write only after that rising edge. As a result, a write checked in its own cycle must still show the old value, and the same write checked in the next cycle must show the new value. Same-line and different-line fill/resolve collisions are driven both directly and from a dense random stream confined to a few lines.

// File: rtl/bp_dir_pkg.sv
`timescale 1ns/1ps
package bp_dir_pkg;

    // Direction encoding held in every slot bit.
    localparam logic DIR_TAKEN     = 1'b1;
    localparam logic DIR_NOT_TAKEN = 1'b0;

    // Seed a slot from the displacement sign: negative (backward) -> taken.
    function automatic logic seed_from_sign(input logic sign_bit);
        return sign_bit ? DIR_TAKEN : DIR_NOT_TAKEN;
    endfunction

    // A resolve survives unless a fill hits the same line this cycle.
    function automatic logic resolve_gate(input logic fill_en,
                                          input logic upd_en,
                                          input logic same_line);
        return upd_en && !(fill_en && same_line);
    endfunction

endpackage

// File: rtl/bp_write_arbiter.sv
`timescale 1ns/1ps
module bp_write_arbiter #(
    parameter int unsigned LINE_W = 10,
    parameter int unsigned SLOT_W = 3,
    localparam int unsigned IDX_W = LINE_W + SLOT_W
) (
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    output logic              fill_we,
    output logic              upd_we,
    output logic [LINE_W-1:0] upd_line,
    output logic [SLOT_W-1:0] upd_slot
);
    import bp_dir_pkg::*;

    typedef struct packed {
        logic              fill_we;
        logic              upd_we;
        logic [LINE_W-1:0] upd_line;
        logic [SLOT_W-1:0] upd_slot;
    } arb_t;

    arb_t arb_d;

    always_comb begin
        arb_d          = '0;
        arb_d.upd_line = upd_idx[IDX_W-1:SLOT_W];
        arb_d.upd_slot = upd_idx[SLOT_W-1:0];
        arb_d.fill_we  = fill_en;
        arb_d.upd_we   = resolve_gate(fill_en, upd_en,
                                      fill_line == arb_d.upd_line);
    end

    assign fill_we  = arb_d.fill_we;
    assign upd_we   = arb_d.upd_we;
    assign upd_line = arb_d.upd_line;
    assign upd_slot = arb_d.upd_slot;

endmodule

// File: rtl/bp_slot_column.sv
`timescale 1ns/1ps
module bp_slot_column #(
    parameter int unsigned LINES   = 1024,
    parameter int unsigned SLOT_W  = 3,
    parameter int unsigned SLOT_ID = 0,
    localparam int unsigned LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_we,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_sign,
    input  logic              upd_we,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [SLOT_W-1:0] upd_slot,
    input  logic              upd_val,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_bit
);
    import bp_dir_pkg::*;

    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(SLOT_ID);

    typedef struct packed {
        logic              fwe;
        logic [LINE_W-1:0] faddr;
        logic              fval;
        logic              uwe;
        logic [LINE_W-1:0] uaddr;
        logic              uval;
    } col_wr_t;

    col_wr_t wr_d;
    logic    col_q [LINES];

    // Next-value computation: both ports, addresses already made disjoint
    // by the arbiter when both are live.
    always_comb begin
        wr_d       = '0;
        wr_d.fwe   = fill_we;
        wr_d.faddr = fill_line;
        wr_d.fval  = seed_from_sign(fill_sign);
        wr_d.uwe   = upd_we && (upd_slot == MY_SLOT);
        wr_d.uaddr = upd_line;
        wr_d.uval  = upd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                col_q[i] <= DIR_NOT_TAKEN;
            end
        end else begin
            if (wr_d.fwe) begin
                col_q[wr_d.faddr] <= wr_d.fval;
            end
            if (wr_d.uwe) begin
                col_q[wr_d.uaddr] <= wr_d.uval;
            end
        end
    end

    assign rd_bit = col_q[rd_line];

endmodule

// File: rtl/bp_read_select.sv
`timescale 1ns/1ps
module bp_read_select #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  line_bits,
    input  logic [SLOT_W-1:0] slot,
    output logic              bit_out
);
    always_comb begin
        bit_out = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot == SLOT_W'(s)) begin
                bit_out = line_bits[s];
            end
        end
    end
endmodule

// File: rtl/bp_dir_predictor.sv
`timescale 1ns/1ps
module bp_dir_predictor #(
    parameter int unsigned LINES = 1024,
    parameter int unsigned SLOTS = 8,
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned IDX_W  = LINE_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [SLOTS-1:0]  fill_signs,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_taken,
    input  logic [IDX_W-1:0]  pred_idx,
    output logic              pred_taken
);
    logic              fill_we;
    logic              upd_we;
    logic [LINE_W-1:0] upd_line;
    logic [SLOT_W-1:0] upd_slot;
    logic [SLOTS-1:0]  rd_bits;

    bp_write_arbiter #(
        .LINE_W (LINE_W),
        .SLOT_W (SLOT_W)
    ) u_arb (
        .fill_en   (fill_en),
        .fill_line (fill_line),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .fill_we   (fill_we),
        .upd_we    (upd_we),
        .upd_line  (upd_line),
        .upd_slot  (upd_slot)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_col
        bp_slot_column #(
            .LINES   (LINES),
            .SLOT_W  (SLOT_W),
            .SLOT_ID (s)
        ) u_col (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_we   (fill_we),
            .fill_line (fill_line),
            .fill_sign (fill_signs[s]),
            .upd_we    (upd_we),
            .upd_line  (upd_line),
            .upd_slot  (upd_slot),
            .upd_val   (upd_taken),
            .rd_line   (pred_idx[IDX_W-1:SLOT_W]),
            .rd_bit    (rd_bits[s])
        );
    end

    bp_read_select #(
        .SLOTS (SLOTS)
    ) u_sel (
        .line_bits (rd_bits),
        .slot      (pred_idx[SLOT_W-1:0]),
        .bit_out   (pred_taken)
    );

endmodule

// File: rtl/bp_dir_checker.sv
`timescale 1ns/1ps
module bp_dir_checker #(
    parameter int unsigned LINES = 1024,
    parameter int unsigned SLOTS = 8,
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned IDX_W  = LINE_W + SLOT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_en,
    input logic [LINE_W-1:0] fill_line,
    input logic [SLOTS-1:0]  fill_signs,
    input logic              upd_en,
    input logic [IDX_W-1:0]  upd_idx,
    input logic              upd_taken,
    input logic [IDX_W-1:0]  pred_idx,
    input logic              pred_taken
);
    logic              armed_q;
    logic              fe_q;
    logic [LINE_W-1:0] fl_q;
    logic [SLOTS-1:0]  fs_q;
    logic              ue_q;
    logic [IDX_W-1:0]  ui_q;
    logic              ut_q;
    logic [IDX_W-1:0]  pi_q;
    logic              pt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            fe_q    <= 1'b0;
            fl_q    <= '0;
            fs_q    <= '0;
            ue_q    <= 1'b0;
            ui_q    <= '0;
            ut_q    <= 1'b0;
            pi_q    <= '0;
            pt_q    <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            fe_q    <= fill_en;
            fl_q    <= fill_line;
            fs_q    <= fill_signs;
            ue_q    <= upd_en;
            ui_q    <= upd_idx;
            ut_q    <= upd_taken;
            pi_q    <= pred_idx;
            pt_q    <= pred_taken;
        end
    end

    logic same_line_q;
    logic rd_hits_fill;
    assign same_line_q  = (fl_q == ui_q[IDX_W-1:SLOT_W]);
    assign rd_hits_fill = (pred_idx[IDX_W-1:SLOT_W] == fl_q);

    // R1: output cleared while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (pred_taken == 1'b0);
        end
    end

    // R2: filled slot reads its seed sign on the following cycle
    a_r2_fill_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && fe_q && rd_hits_fill)
        |-> (pred_taken == fs_q[pred_idx[SLOT_W-1:0]]));

    // R4: a surviving resolve is readable on the following cycle
    a_r4_resolve_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ue_q && !(fe_q && same_line_q) && pred_idx == ui_q)
        |-> (pred_taken == ut_q));

    // R5: same-line collision keeps the fill value
    a_r5_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ue_q && fe_q && same_line_q && pred_idx == ui_q)
        |-> (pred_taken == fs_q[ui_q[SLOT_W-1:0]]));

    // R8: idle cycle leaves the read value unchanged
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !fe_q && !ue_q && pred_idx == pi_q)
        |-> (pred_taken == pt_q));

endmodule

bind bp_dir_predictor bp_dir_checker #(
    .LINES (LINES),
    .SLOTS (SLOTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_line  (fill_line),
    .fill_signs (fill_signs),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_taken  (upd_taken),
    .pred_idx   (pred_idx),
    .pred_taken (pred_taken)
);

// File: tb/bp_dir_predictor_bench.sv
`timescale 1ns/1ps
module bp_dir_predictor_bench;
    localparam int LINES = 1024;
    localparam int SLOTS = 8;
    localparam int SW    = 3;
    localparam int LW    = 10;
    localparam int IW    = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fill_en;
    logic [LW-1:0] fill_line;
    logic [7:0]    fill_signs;
    logic          upd_en;
    logic [IW-1:0] upd_idx;
    logic          upd_taken;
    logic [IW-1:0] pred_idx;
    logic          pred_taken;

    int vectors    = 0;
    int miscompares = 0;
    bit model [LINES*SLOTS];

    always #2.5 clk = ~clk;   // 200 MHz

    bp_dir_predictor u_bp_dir_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_en),
        .fill_line  (fill_line),
        .fill_signs (fill_signs),
        .upd_en     (upd_en),
        .upd_idx    (upd_idx),
        .upd_taken  (upd_taken),
        .pred_idx   (pred_idx),
        .pred_taken (pred_taken)
    );

    function automatic logic [IW-1:0] ix(input int line, input int slot);
        return IW'(line * SLOTS + slot);
    endfunction

    // Drive one cycle, compare the same-cycle read, then advance the model.
    task automatic apply(input logic fe, input int fl, input logic [7:0] fs,
                         input logic ue, input logic [IW-1:0] ui, input logic ut,
                         input logic [IW-1:0] pi, input string tag);
        fill_en    = fe;
        fill_line  = LW'(fl);
        fill_signs = fs;
        upd_en     = ue;
        upd_idx    = ui;
        upd_taken  = ut;
        pred_idx   = pi;
        #1;
        vectors++;
        if (pred_taken !== model[pi]) begin
            miscompares++;
            $display("FAIL %s idx=%0d actual=%0b expected=%0b",
                     tag, pi, pred_taken, model[pi]);
        end
        @(posedge clk);
        if (rst_n) begin
            if (ue && !(fe && fl == int'(ui[IW-1:SW]))) model[ui] = ut;
            if (fe) begin
                for (int s = 0; s < SLOTS; s++) model[fl*SLOTS + s] = fs[s];
            end
        end
        @(negedge clk);
    endtask

    task automatic peek(input logic [IW-1:0] pi, input string tag);
        apply(1'b0, 0, 8'h00, 1'b0, '0, 1'b0, pi, tag);
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        fill_en = 1'b0; fill_line = '0; fill_signs = '0;
        upd_en = 1'b0; upd_idx = '0; upd_taken = 1'b0; pred_idx = '0;
        @(negedge clk);

        // R1: writes presented during reset are ignored, reads give 0
        apply(1'b1, 3, 8'hFF, 1'b1, ix(3, 2), 1'b1, ix(3, 2), "R1");
        apply(1'b0, 0, 8'h00, 1'b1, ix(4, 0), 1'b1, ix(3, 0), "R1");
        rst_n = 1'b1;
        peek(ix(3, 2), "R1");
        peek(ix(4, 0), "R1");
        peek(ix(LINES-1, 7), "R1");

        // R2/R3: seed line 5 from signs (bit s = slot s, 1 = backward = taken)
        apply(1'b1, 5, 8'b1010_0110, 1'b0, '0, 1'b0, ix(5, 1), "R7");
        for (int s = 0; s < SLOTS; s++) peek(ix(5, s), "R2");
        for (int s = 0; s < SLOTS; s++) peek(ix(4, s), "R3");
        for (int s = 0; s < SLOTS; s++) peek(ix(6, s), "R3");

        // R4: resolve slot 0 of line 5 taken, others untouched
        apply(1'b0, 0, 8'h00, 1'b1, ix(5, 0), 1'b1, ix(5, 0), "R7");
        peek(ix(5, 0), "R4");
        peek(ix(5, 1), "R4");
        apply(1'b0, 0, 8'h00, 1'b1, ix(5, 2), 1'b0, ix(5, 3), "R4");
        peek(ix(5, 2), "R4");

        // R5: fill and resolve on the same line, fill wins
        apply(1'b1, 7, 8'h00, 1'b1, ix(7, 3), 1'b1, ix(7, 3), "R5");
        peek(ix(7, 3), "R5");
        apply(1'b1, 7, 8'hFF, 1'b1, ix(7, 6), 1'b0, ix(7, 6), "R5");
        peek(ix(7, 6), "R5");

        // R6: fill and resolve on different lines both land
        apply(1'b1, 9, 8'hFF, 1'b1, ix(5, 1), 1'b0, ix(9, 4), "R6");
        peek(ix(9, 4), "R6");
        peek(ix(5, 1), "R6");

        // R8: idle cycles hold contents
        for (int k = 0; k < 4; k++) peek(ix(5, k), "R8");

        // R7 plus mixed traffic: dense stream on a few lines
        for (int n = 0; n < 3000; n++) begin
            int fl;
            fl = int'($urandom % 16);
            apply(($urandom % 6) == 0, fl, 8'($urandom),
                  ($urandom % 2) == 0, ix(int'($urandom % 16), int'($urandom % 8)),
                  1'($urandom),
                  ix(int'($urandom % 16), int'($urandom % 8)), "R7_R6_mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule